// File: doc/BRIEF.md
# Cascadable CAM Host Cycle and Match-Chain Controller

This block sits on the host side of a content-addressable memory that can be cascaded with other devices. It runs on one system clock. It watches an asynchronous active-low access strobe and detects the strobe's edges. Each falling edge opens a bus cycle, and each rising edge closes it.

When a cycle opens, the block captures the read/write select, the command/data select and the chain-enable input. It decodes them into one of four cycle kinds. For read cycles it enables the 16-bit data bus drivers. When a cycle closes, the block does three things:

- It releases the bus.
- It sends one advance pulse to the segment counters.
- It locks the chain state for the cycles that follow.

The active-low match output merges a held local compare hit with the upstream match input. It is active only while the chain is locked on. In a cascade, the highest-priority matching device therefore decides the flag at the end of the chain. A configuration switch pulse forces the flag inactive and unlocks the chain.

Top module: `cam_cycle_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `match_n` is 1, `dq_oe` is all zeros, `cycle_kind` is 0 (idle) and `seg_adv` is 0.
- R2: `strobe_n` passes through a two-flop synchronizer and an edge detector. Outputs therefore change on the third rising clock edge after a strobe transition, and still show the old state after the second edge.
- R3: On a falling strobe edge, `cycle_kind` takes a value from the captured selects and holds it until the rising edge, when it returns to 0. The encodings are:
  - `wr_n`=0, `cmd_n`=0 gives 1 (command write).
  - `wr_n`=0, `cmd_n`=1 gives 2 (data write).
  - `wr_n`=1, `cmd_n`=0 gives 3 (command read).
  - `wr_n`=1, `cmd_n`=1 gives 4 (data read).
- R4: `dq_oe` is all ones only during read cycles, from the falling edge until the rising edge. It is all zeros for write cycles and whenever the synchronized strobe is high.
- R5: Each rising strobe edge produces exactly one single-cycle `seg_adv` pulse, together with `cycle_kind` returning to idle.
- R6: After a rising edge that locks the chain on (chain-enable captured 0 at the falling edge), `match_n` is 0 in either of two cases: a local hit is held and `rpt_en`=1, or `match_in_n`=0. It is 1 otherwise. It tracks these inputs one clock later. A `local_match` pulse sets the held hit.
- R7: With the chain locked on and `rpt_en`=0, a held local hit has no effect, and `match_n` follows `match_in_n` one clock later.
- R8: A rising edge whose cycle captured chain-enable as 1 locks the chain off, and `match_n` is 1 from then on, whatever the value of `match_in_n`.
- R9: A `cfg_switch` pulse makes `match_n` 1 on the next clock. It also clears the held hit and unlocks the chain.
- R10: A chain-enable or upstream match held low during reset does not make `match_n` go low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Asynchronous active-low access strobe |
| wr_n | input | 1 | 0 = write cycle, 1 = read cycle |
| cmd_n | input | 1 | 0 = command cycle, 1 = data cycle |
| chain_en_n | input | 1 | Active-low chain enable, captured at strobe fall |
| match_in_n | input | 1 | Active-low match from upstream device |
| local_match | input | 1 | Single-cycle local compare hit pulse |
| rpt_en | input | 1 | Local match reporting enable (control setting) |
| cfg_switch | input | 1 | Single-cycle active configuration switch pulse |
| match_n | output | 1 | Registered active-low match flag to downstream |
| dq_oe | output | 16 | Data bus drive enable, one bit per lane |
| cycle_kind | output | 3 | Current cycle: 0 idle, 1..4 as in R3 |
| seg_adv | output | 1 | Segment counter advance pulse |

## Verification
There are two classes of internal error, and they show up at different times.

- **Wrong captured select or synchronizer stage.** This shows at the ports three clocks after the strobe edge, as a wrong `cycle_kind` or `dq_oe`. A lost edge shows at the same point as a missing or doubled `seg_adv`.
- **Wrong chain lock or held hit.** This stays hidden until the match flag is asked to reflect it. It can only be seen on the clock after a rising edge, a `match_in_n` change or a `local_match` pulse. The bench therefore varies each of these while the chain is locked both on and off.

// File: rtl/cam_cyc_pkg.sv
package cam_cyc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_CMD_WR = 3'd1,
    CYC_DAT_WR = 3'd2,
    CYC_CMD_RD = 3'd3,
    CYC_DAT_RD = 3'd4
  } cyc_kind_e;

  function automatic cyc_kind_e decode_kind(input logic wr_n, input logic cmd_n);
    case ({wr_n, cmd_n})
      2'b00:   return CYC_CMD_WR;
      2'b01:   return CYC_DAT_WR;
      2'b10:   return CYC_CMD_RD;
      default: return CYC_DAT_RD;
    endcase
  endfunction

endpackage

// File: rtl/cam_strobe_sync.sv
module cam_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n_async,
  output logic strobe_idle,
  output logic fall_p,
  output logic rise_p
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= strobe_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[LAST];
  end

  assign fall_p      = prev_q & ~sync_q[LAST];
  assign rise_p      = ~prev_q & sync_q[LAST];
  assign strobe_idle = prev_q;

endmodule

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_cyc_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fall_p,
  input  logic            rise_p,
  input  logic            strobe_idle,
  input  logic            wr_n,
  input  logic            cmd_n,
  input  logic            chain_en_n,
  output cyc_kind_e       kind_q,
  output logic [DQ_W-1:0] dq_oe_q,
  output logic            seg_adv_q,
  output logic            ec_cap_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= CYC_IDLE;
      dq_oe_q   <= '0;
      seg_adv_q <= 1'b0;
      ec_cap_n  <= 1'b1;
    end else begin
      seg_adv_q <= rise_p;
      if (fall_p) begin
        kind_q   <= decode_kind(wr_n, cmd_n);
        dq_oe_q  <= {DQ_W{wr_n}};
        ec_cap_n <= chain_en_n;
      end else if (rise_p) begin
        kind_q  <= CYC_IDLE;
        dq_oe_q <= '0;
      end
    end
  end

  // R4: bus released whenever the synchronized strobe is high
  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    strobe_idle |-> (dq_oe_q == '0));

  // R4: write cycles never drive the bus
  p_write_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (kind_q == CYC_CMD_WR || kind_q == CYC_DAT_WR) |-> (dq_oe_q == '0));

  // R5: advance is a single-cycle pulse
  p_adv_single_r5: assert property (@(posedge clk) disable iff (rst)
    seg_adv_q |=> !seg_adv_q);

  // R5: advance coincides with the return to idle
  p_adv_idle_r5: assert property (@(posedge clk) disable iff (rst)
    seg_adv_q |-> (kind_q == CYC_IDLE));

endmodule

// File: rtl/cam_match_chain.sv
module cam_match_chain (
  input  logic clk,
  input  logic rst,
  input  logic rise_p,
  input  logic ec_cap_n,
  input  logic match_in_n,
  input  logic local_match,
  input  logic rpt_en,
  input  logic cfg_switch,
  output logic match_n_q
);
  logic chain_on_q, hit_q;
  logic chain_nx, hit_nx, match_nx;

  always_comb begin
    if (cfg_switch)  chain_nx = 1'b0;
    else if (rise_p) chain_nx = ~ec_cap_n;
    else             chain_nx = chain_on_q;

    hit_nx = cfg_switch ? 1'b0 : (hit_q | local_match);

    if (cfg_switch)    match_nx = 1'b1;
    else if (chain_nx) match_nx = ~((hit_q & rpt_en) | ~match_in_n);
    else               match_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_on_q <= 1'b0;
      hit_q      <= 1'b0;
      match_n_q  <= 1'b1;
    end else begin
      chain_on_q <= chain_nx;
      hit_q      <= hit_nx;
      match_n_q  <= match_nx;
    end
  end

  // R9: configuration switch forces the flag inactive
  p_cfg_high_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_switch |=> match_n_q);

  // R8: closing a cycle with chain disabled leaves the flag inactive
  p_ec_high_r8: assert property (@(posedge clk) disable iff (rst)
    (rise_p && ec_cap_n) |=> match_n_q);

  // R6: an active flag needs an upstream match or a reported local hit
  p_low_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    !match_n_q |-> ($past(!match_in_n) || $past(hit_q && rpt_en)));

endmodule

// File: rtl/cam_cycle_ctrl.sv
module cam_cycle_ctrl
  import cam_cyc_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe_n,
  input  logic            wr_n,
  input  logic            cmd_n,
  input  logic            chain_en_n,
  input  logic            match_in_n,
  input  logic            local_match,
  input  logic            rpt_en,
  input  logic            cfg_switch,
  output logic            match_n,
  output logic [DQ_W-1:0] dq_oe,
  output logic [2:0]      cycle_kind,
  output logic            seg_adv
);
  logic      strobe_idle, fall_p, rise_p, ec_cap_n;
  cyc_kind_e kind;

  cam_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk            (clk),
    .rst            (rst),
    .strobe_n_async (strobe_n),
    .strobe_idle    (strobe_idle),
    .fall_p         (fall_p),
    .rise_p         (rise_p)
  );

  cam_cycle_decode #(.DQ_W(DQ_W)) u_decode (
    .clk         (clk),
    .rst         (rst),
    .fall_p      (fall_p),
    .rise_p      (rise_p),
    .strobe_idle (strobe_idle),
    .wr_n        (wr_n),
    .cmd_n       (cmd_n),
    .chain_en_n  (chain_en_n),
    .kind_q      (kind),
    .dq_oe_q     (dq_oe),
    .seg_adv_q   (seg_adv),
    .ec_cap_n    (ec_cap_n)
  );

  cam_match_chain u_chain (
    .clk         (clk),
    .rst         (rst),
    .rise_p      (rise_p),
    .ec_cap_n    (ec_cap_n),
    .match_in_n  (match_in_n),
    .local_match (local_match),
    .rpt_en      (rpt_en),
    .cfg_switch  (cfg_switch),
    .match_n_q   (match_n)
  );

  assign cycle_kind = kind;

  // R4: the bus is never driven while the flag logic sees an idle cycle
  p_idle_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (cycle_kind == 3'd0) |-> (dq_oe == '0));

endmodule

// File: tb/cam_cycle_ctrl_tb_top.sv
module cam_cycle_ctrl_tb_top;
  import cam_cyc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DQ_W       = 16;

  logic clk = 0, rst = 1, strobe_n = 1, wr_n = 1, cmd_n = 1, chain_en_n = 1;
  logic match_in_n = 1, local_match = 0, rpt_en = 1, cfg_switch = 0;
  logic match_n, seg_adv;
  logic [DQ_W-1:0] dq_oe;
  logic [2:0] cycle_kind;

  int cyc = 0, total = 0, bad = 0;

  cam_cycle_ctrl #(.DQ_W(DQ_W)) dut_i (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .wr_n(wr_n), .cmd_n(cmd_n),
    .chain_en_n(chain_en_n), .match_in_n(match_in_n), .local_match(local_match),
    .rpt_en(rpt_en), .cfg_switch(cfg_switch), .match_n(match_n),
    .dq_oe(dq_oe), .cycle_kind(cycle_kind), .seg_adv(seg_adv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    string      tag;
    logic       m;
    logic       oe;
    logic [2:0] k;
    logic       adv;
  } exp_t;
  exp_t q[$];

  // bench-side model
  logic m_chain = 0, m_hit = 0, m_ec = 1, m_oe = 0, m_adv = 0;
  logic [2:0] m_kind = 3'd0;

  function automatic logic f_match();
    return m_chain ? ~((m_hit & rpt_en) | ~match_in_n) : 1'b1;
  endfunction

  function automatic logic [2:0] f_kind(input logic w, input logic c);
    return {w, c} == 2'b00 ? 3'd1 : {w, c} == 2'b01 ? 3'd2 : {w, c} == 2'b10 ? 3'd3 : 3'd4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic push(input int d, input string t);
    exp_t e;
    e.due = cyc + d; e.tag = t; e.m = f_match(); e.oe = m_oe; e.k = m_kind; e.adv = m_adv;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " match_n"}, 32'(match_n), 32'(e.m));
      chk({e.tag, " dq_oe"}, 32'(dq_oe), 32'({DQ_W{e.oe}}));
      chk({e.tag, " cycle_kind"}, 32'(cycle_kind), 32'(e.k));
      chk({e.tag, " seg_adv"}, 32'(seg_adv), 32'(e.adv));
    end
  end

  task automatic open_cycle(input logic w, input logic c, input logic ec, input string t);
    @(posedge clk); #1;
    wr_n = w; cmd_n = c; chain_en_n = ec; strobe_n = 0;
    push(2, {"R2 before fall ", t});
    m_kind = f_kind(w, c); m_oe = w; m_ec = ec; m_adv = 0;
    push(3, t);
    repeat (4) @(posedge clk);
  endtask

  task automatic close_cycle(input string t);
    @(posedge clk); #1;
    strobe_n = 1;
    push(2, {"R2 before rise ", t});
    m_kind = 3'd0; m_oe = 0; m_adv = 1; m_chain = ~m_ec;
    push(3, {"R5 ", t});
    m_adv = 0;
    push(4, {"R5 pulse end ", t});
    repeat (5) @(posedge clk);
  endtask

  task automatic pulse_local(input string t);
    @(posedge clk); #1;
    local_match = 1;
    push(1, {t, " pre"});
    m_hit = 1;
    push(2, t);
    @(posedge clk); #1;
    local_match = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse_cfg(input string t);
    @(posedge clk); #1;
    cfg_switch = 1;
    m_chain = 0; m_hit = 0;
    push(1, t);
    @(posedge clk); #1;
    cfg_switch = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic set_upstream(input logic v, input string t);
    @(posedge clk); #1;
    match_in_n = v;
    push(1, t);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: chain enable and upstream match held low during reset
    rst = 1; chain_en_n = 0; match_in_n = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 R10 match_n after reset", 32'(match_n), 32'd1);
    chk("R1 dq_oe after reset", 32'(dq_oe), 32'd0);
    chk("R1 cycle_kind after reset", 32'(cycle_kind), 32'd0);
    chk("R1 seg_adv after reset", 32'(seg_adv), 32'd0);
    @(posedge clk); #1;
    chain_en_n = 1; match_in_n = 1;
    repeat (3) @(posedge clk);

    open_cycle(0, 0, 1, "R3 command write");
    close_cycle("R8 chain off after cmd write");
    open_cycle(0, 1, 0, "R3 data write");
    close_cycle("R6 chain on no source");
    pulse_local("R6 local hit reported");
    open_cycle(1, 0, 0, "R3 R4 command read");
    close_cycle("R6 hit held across cycle");
    pulse_cfg("R9 config switch");
    rpt_en = 0;
    open_cycle(1, 1, 0, "R3 R4 data read");
    pulse_local("R7 hit while unlocked");
    close_cycle("R7 report off hit ignored");
    set_upstream(0, "R7 follow upstream low");
    set_upstream(1, "R7 follow upstream high");
    set_upstream(0, "R6 upstream pass");
    open_cycle(0, 0, 1, "R3 cmd write chain held");
    close_cycle("R8 chain disabled");
    set_upstream(0, "R8 upstream ignored");
    set_upstream(1, "R8 upstream release");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule